// File: doc/BRIEF.md
# DDR Read Burst Interruption Sequencer

This block sits on the memory side of a double-data-rate SDRAM model. It follows read bursts and decides, for every clock, which column index each of the two data beats carries (one beat on the rising edge, one on the falling edge). It also reports which bank supplies the data and drives an enable for the data strobe. The storage array is not modelled: a beat carries the column index it would read, so a checker can see exactly which word would be on the bus.

Commands arrive one per clock with a bank and a start column. A READ starts a burst whose beats come out after the configured CAS latency. A later READ to any bank cuts the running burst short. A PRECHARGE to the bank being read ends output one CAS latency after it was issued. The number of beats a burst really delivers therefore depends on how far apart the commands are.

Top module: `ddr_rd_interrupt_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, both beat-valid flags, `dqs_en` and `proto_err` are low.
- R2: `cmd` encodes 2'b00 as NOP, 2'b01 as READ and 2'b10 as PRECHARGE. The value 2'b11 (read and precharge together) is illegal: it starts no burst, and from the next cycle on `proto_err` is high and stays high until reset.
- R3: The first beat pair of a READ sampled at clock edge N appears after edge N+CL, where CL = `cfg_cl` lies between 2 and MAX_CL.
- R4: `cfg_bl` selects the burst length: 0 gives 2 beats, 1 gives 4 beats and 2 gives 8 beats. A burst that nothing interrupts lasts BL/2 cycles with both valid flags high, and then both flags drop.
- R5: Pair i of a burst that starts at column C carries, on the rising edge, C with its low log2(BL) bits replaced by (C + 2i) mod BL, and on the falling edge the column that follows it inside the same aligned BL block. Upper column bits never change. `rd_bank` shows the bank of the burst.
- R6: A READ to any bank, issued k >= 1 clocks after an earlier READ, leaves exactly 2k beats of the earlier burst (capped at BL). The new burst follows in the very next cycle, with no gap.
- R7: A PRECHARGE to the bank being read, issued p >= 1 clocks after the READ, leaves 2p beats (capped at BL). Both valid flags are low from the cycle after the last of them.
- R8: A PRECHARGE to a bank other than the one being read does not change the active burst.
- R9: `dqs_en` rises one cycle before the first valid pair (preamble) and stays high through every valid pair, including across bursts that follow one another directly. It falls in the cycle after the last valid pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Command code: NOP, READ, PRECHARGE |
| cmd_bank | input | BANK_W | Bank addressed by the command |
| cmd_col | input | COL_W | Start column of a READ |
| cfg_bl | input | 2 | Burst length select |
| cfg_cl | input | $clog2(MAX_CL+1) | CAS latency in clocks |
| beat_r_vld | output | 1 | Rising-edge beat valid |
| beat_f_vld | output | 1 | Falling-edge beat valid |
| beat_r_col | output | COL_W | Column carried by the rising-edge beat |
| beat_f_col | output | COL_W | Column carried by the falling-edge beat |
| rd_bank | output | BANK_W | Bank being read out |
| dqs_en | output | 1 | Data strobe enable, including the preamble |
| proto_err | output | 1 | Sticky flag for an illegal command |

## Verification
The assertions assume that `cfg_cl` always lies between 2 and MAX_CL. They also assume that `cfg_bl` and `cfg_cl` change only while no command is in flight, because a burst takes its length when it starts and its latency from the pipeline tap. The stimulus sets both settings during reset or in idle gaps that are longer than any latency plus burst. It issues the illegal code only in the last scenario, so that the sticky flag does not hide the earlier expectations.

// File: rtl/ddr_rd_interrupt_seq.sv
module ddr_rd_interrupt_seq #(
  parameter int COL_W  = 10,
  parameter int BANK_W = 2,
  parameter int MAX_CL = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   cmd,
  input  logic [BANK_W-1:0]            cmd_bank,
  input  logic [COL_W-1:0]             cmd_col,
  input  logic [1:0]                   cfg_bl,
  input  logic [$clog2(MAX_CL+1)-1:0]  cfg_cl,
  output logic                         beat_r_vld,
  output logic                         beat_f_vld,
  output logic [COL_W-1:0]             beat_r_col,
  output logic [COL_W-1:0]             beat_f_col,
  output logic [BANK_W-1:0]            rd_bank,
  output logic                         dqs_en,
  output logic                         proto_err
);
  localparam int CLW  = $clog2(MAX_CL+1);
  localparam int IDXW = (MAX_CL > 1) ? $clog2(MAX_CL) : 1;

  logic [MAX_CL-1:0] p_rd, p_pre;
  logic [BANK_W-1:0] p_bank [MAX_CL];
  logic [COL_W-1:0]  p_col  [MAX_CL];

  logic [IDXW-1:0]   tap;
  logic              t_rd, t_pre;
  logic [BANK_W-1:0] t_bank;
  logic [COL_W-1:0]  t_col;

  logic              s_vld, n_vld;
  logic [BANK_W-1:0] s_bank, n_bank;
  logic [COL_W-1:0]  s_col, n_col;
  logic [1:0]        s_idx, n_idx, s_last, n_last, ld_last;
  logic [2:0]        s_mask, n_mask, ld_mask;
  logic [2:0]        r_off, f_off, blk;

  assign tap    = IDXW'(cfg_cl - CLW'(1));
  assign t_rd   = p_rd[tap];
  assign t_pre  = p_pre[tap];
  assign t_bank = p_bank[tap];
  assign t_col  = p_col[tap];

  always_comb begin
    case (cfg_bl)
      2'd0:    begin ld_last = 2'd0; ld_mask = 3'd1; end
      2'd1:    begin ld_last = 2'd1; ld_mask = 3'd3; end
      default: begin ld_last = 2'd3; ld_mask = 3'd7; end
    endcase
  end

  always_comb begin
    n_vld  = s_vld;
    n_bank = s_bank;
    n_col  = s_col;
    n_idx  = s_idx;
    n_last = s_last;
    n_mask = s_mask;
    if (t_rd) begin
      n_vld  = 1'b1;
      n_bank = t_bank;
      n_col  = t_col;
      n_idx  = 2'd0;
      n_last = ld_last;
      n_mask = ld_mask;
    end else if (s_vld && t_pre && t_bank == s_bank) begin
      n_vld = 1'b0;
    end else if (s_vld) begin
      if (s_idx == s_last) n_vld = 1'b0;
      else                 n_idx = s_idx + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_rd      <= '0;
      p_pre     <= '0;
      for (int j = 0; j < MAX_CL; j++) begin
        p_bank[j] <= '0;
        p_col[j]  <= '0;
      end
      s_vld     <= 1'b0;
      s_bank    <= '0;
      s_col     <= '0;
      s_idx     <= '0;
      s_last    <= '0;
      s_mask    <= '0;
      proto_err <= 1'b0;
    end else begin
      p_rd[0]   <= (cmd == 2'b01);
      p_pre[0]  <= (cmd == 2'b10);
      p_bank[0] <= cmd_bank;
      p_col[0]  <= cmd_col;
      for (int j = 1; j < MAX_CL; j++) begin
        p_rd[j]   <= p_rd[j-1];
        p_pre[j]  <= p_pre[j-1];
        p_bank[j] <= p_bank[j-1];
        p_col[j]  <= p_col[j-1];
      end
      s_vld  <= n_vld;
      s_bank <= n_bank;
      s_col  <= n_col;
      s_idx  <= n_idx;
      s_last <= n_last;
      s_mask <= n_mask;
      if (cmd == 2'b11) proto_err <= 1'b1;
    end
  end

  assign r_off = 3'(s_col[2:0] + {s_idx, 1'b0}) & s_mask;
  assign f_off = 3'(r_off + 3'd1) & s_mask;
  assign blk   = s_col[2:0] & ~s_mask;

  assign beat_r_vld = s_vld;
  assign beat_f_vld = s_vld;
  assign beat_r_col = {s_col[COL_W-1:3], blk | r_off};
  assign beat_f_col = {s_col[COL_W-1:3], blk | f_off};
  assign rd_bank    = s_bank;
  assign dqs_en     = s_vld | n_vld;

  p_cl_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cl >= CLW'(2)) && (cfg_cl <= CLW'(MAX_CL)));

  p_err_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b11) |=> proto_err);

  p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  p_fall_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_f_vld |-> ((((beat_f_col ^ beat_r_col) & ~{{(COL_W-3){1'b0}}, s_mask}) == '0)
                    && ((3'(beat_f_col[2:0] - beat_r_col[2:0]) & s_mask) == 3'd1)));

  p_pre_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (t_pre && !t_rd && beat_r_vld && t_bank == rd_bank) |=> !beat_r_vld);

  p_preamble_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beat_r_vld) |-> $past(dqs_en));

  p_strobe_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dqs_en) |-> (!beat_r_vld && $past(beat_r_vld)));
endmodule

// File: tb/ddr_rd_interrupt_seq_tb.sv
`timescale 1ns/1ps
module ddr_rd_interrupt_seq_tb;
  localparam int COL_W = 10, BANK_W = 2, MAX_CL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic [BANK_W-1:0] cmd_bank = '0;
  logic [COL_W-1:0] cmd_col = '0;
  logic [1:0] cfg_bl = 2'd2;
  logic [2:0] cfg_cl = 3'd2;
  logic beat_r_vld, beat_f_vld, dqs_en, proto_err;
  logic [COL_W-1:0] beat_r_col, beat_f_col;
  logic [BANK_W-1:0] rd_bank;

  ddr_rd_interrupt_seq #(.COL_W(COL_W), .BANK_W(BANK_W), .MAX_CL(MAX_CL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .cfg_bl(cfg_bl), .cfg_cl(cfg_cl), .beat_r_vld(beat_r_vld), .beat_f_vld(beat_f_vld),
    .beat_r_col(beat_r_col), .beat_f_col(beat_f_col), .rd_bank(rd_bank),
    .dqs_en(dqs_en), .proto_err(proto_err));

  always #2 clk = ~clk;

  typedef struct {
    int cyc; bit vld; int rcol; int fcol; int bank; bit dqs; bit err; string req;
  } item_t;
  item_t sb[$];

  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int bcol(int col, int bl, int k);
    return (col & ~(bl - 1)) | ((col + k) & (bl - 1));
  endfunction

  task automatic exp_idle(int c, bit dqs, bit err, string req);
    item_t it;
    it.cyc = c; it.vld = 0; it.rcol = 0; it.fcol = 0; it.bank = 0;
    it.dqs = dqs; it.err = err; it.req = req;
    sb.push_back(it);
  endtask

  task automatic exp_pairs(int c, int bank, int col, int bl, int first, int n, string req);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.cyc = c + i; it.vld = 1; it.bank = bank; it.dqs = 1; it.err = 0; it.req = req;
      it.rcol = bcol(col, bl, 2 * (first + i));
      it.fcol = bcol(col, bl, 2 * (first + i) + 1);
      sb.push_back(it);
    end
  endtask

  task automatic send(logic [1:0] c, int b, int col);
    cmd = c; cmd_bank = BANK_W'(b); cmd_col = COL_W'(col);
    @(negedge clk);
    cmd = 2'b00;
  endtask

  task automatic idle(int n);
    cmd = 2'b00;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && sb.size() > 0 && sb[0].cyc == cyc) begin
      item_t e;
      e = sb.pop_front();
      checks++;
      if (beat_r_vld !== e.vld || beat_f_vld !== e.vld || dqs_en !== e.dqs ||
          proto_err !== e.err ||
          (e.vld && (int'(beat_r_col) != e.rcol || int'(beat_f_col) != e.fcol ||
                     int'(rd_bank) != e.bank))) begin
        fails++;
        $display("FAIL %s cyc %0d: actual vld=%b/%b r=%0h f=%0h bank=%0d dqs=%b err=%b expected vld=%b r=%0h f=%0h bank=%0d dqs=%b err=%b",
                 e.req, cyc, beat_r_vld, beat_f_vld, beat_r_col, beat_f_col, rd_bank,
                 dqs_en, proto_err, e.vld, e.rcol, e.fcol, e.bank, e.dqs, e.err);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual still running, expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int e;
    repeat (4) @(negedge clk);
    // R1: outputs quiet in reset
    checks++;
    if (beat_r_vld || beat_f_vld || dqs_en || proto_err) begin
      fails++;
      $display("FAIL R1 in reset: actual vld=%b%b dqs=%b err=%b expected all 0",
               beat_r_vld, beat_f_vld, dqs_en, proto_err);
    end
    rst_n = 1'b1;
    @(negedge clk);
    exp_idle(cyc + 1, 0, 0, "R1");
    idle(2);

    // R3 R4 R5 R9: BL8 CL2 uninterrupted, start inside block
    cfg_bl = 2'd2; cfg_cl = 3'd2; idle(2);
    e = cyc + 1;
    exp_idle(e + 1, 1, 0, "R9 preamble");
    exp_pairs(e + 2, 1, 'h05, 8, 0, 4, "R4/R5 BL8");
    exp_idle(e + 6, 0, 0, "R4/R9 end");
    send(2'b01, 1, 'h05); idle(10);

    // R3 R4 R5: BL4 CL3 with wrap
    cfg_bl = 2'd1; cfg_cl = 3'd3; idle(2);
    e = cyc + 1;
    exp_idle(e + 2, 1, 0, "R3/R9 preamble CL3");
    exp_pairs(e + 3, 2, 'h13, 4, 0, 2, "R3/R5 BL4 wrap");
    exp_idle(e + 5, 0, 0, "R4 end BL4");
    send(2'b01, 2, 'h13); idle(10);

    // R3 R4 R5: BL2 CL4 top column
    cfg_bl = 2'd0; cfg_cl = 3'd4; idle(2);
    e = cyc + 1;
    exp_idle(e + 3, 1, 0, "R3/R9 preamble CL4");
    exp_pairs(e + 4, 3, 'h3FF, 2, 0, 1, "R3/R5 BL2");
    exp_idle(e + 5, 0, 0, "R4 end BL2");
    send(2'b01, 3, 'h3FF); idle(10);

    // R6 R9: read interrupted by reads, spacing 1 then 2
    cfg_bl = 2'd2; cfg_cl = 3'd2; idle(2);
    e = cyc + 1;
    exp_idle(e + 1, 1, 0, "R9 preamble");
    exp_pairs(e + 2, 0, 'h08, 8, 0, 1, "R6 first cut at 1");
    exp_pairs(e + 3, 2, 'h20, 8, 0, 2, "R6 second cut at 2");
    exp_pairs(e + 5, 1, 'h31, 8, 0, 4, "R6 last full");
    exp_idle(e + 9, 0, 0, "R6/R9 end");
    send(2'b01, 0, 'h08); send(2'b01, 2, 'h20); idle(1); send(2'b01, 1, 'h31); idle(12);

    // R7: precharge same bank at spacing 1, 2, 3
    for (int p = 1; p <= 3; p++) begin
      e = cyc + 1;
      exp_idle(e + 1, 1, 0, "R7 preamble");
      exp_pairs(e + 2, 1, 'h40, 8, 0, p, "R7 cut by precharge");
      exp_idle(e + 2 + p, 0, 0, "R7 stop");
      send(2'b01, 1, 'h40); idle(p - 1); send(2'b10, 1, 0); idle(10);
    end

    // R8: precharge to another bank ignored
    cfg_bl = 2'd1; idle(2);
    e = cyc + 1;
    exp_pairs(e + 2, 1, 'h06, 4, 0, 2, "R8 other bank");
    exp_idle(e + 4, 0, 0, "R8 end");
    send(2'b01, 1, 'h06); send(2'b10, 2, 0); idle(10);

    // R2: illegal code starts nothing, sets sticky error
    cfg_bl = 2'd2; idle(2);
    e = cyc + 1;
    for (int k = 0; k < 6; k++) exp_idle(e + k, 0, 1, "R2 illegal");
    send(2'b11, 1, 'h10); idle(10);

    while (sb.size() > 0) begin
      item_t x;
      x = sb.pop_front();
      checks++; fails++;
      $display("FAIL %s: actual not compared, expected item at cyc %0d", x.req, x.cyc);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule